// File: doc/BRIEF.md
# PTP Event Frame Classifier

This block sits on the receive path of an Ethernet MAC and inspects each incoming frame as it streams past, one byte per accepted transfer, starting with the byte that follows the start-of-frame delimiter (the delimiter itself, 8'b10101011, is not presented). It decides whether the frame is a precision time protocol message carried in UDP over IPv4, without storing the frame. Each field is compared against fixed constants in the cycle its byte arrives: the IPv4 destination address against four multicast groups, the UDP destination port against the event and general port numbers, and the message control byte against the known message codes.

When the frame-end byte is accepted, the verdict is registered. It is presented for one cycle with a result-valid pulse. The verdict holds:
- a match flag,
- an event/general indication,
- a message type code or an unknown-type flag,
- a 2-bit domain code,
- a general-purpose event bit that downstream filing logic can use to steer the frame to a chosen queue.

The input is a valid/ready byte stream. The classifier never applies back-pressure, so `s_ready` is held high and a byte is taken on every cycle in which `s_valid` is high. The sender may insert idle cycles anywhere. `s_sof`, `s_eof` and `s_data` are meaningful only while `s_valid` is high.

Top module: `ptp_frame_classifier`

## Requirements
- R1: The byte accepted with `s_sof` high is offset 0, and each later accepted byte is the next offset. A byte accepted after a frame-end byte, or after reset, is also offset 0. An `s_sof` in the middle of a frame discards that frame and starts a new one.
- R2: A frame matches only if offsets 30, 31, 32 and 33 hold 224, 0, 1 and a value from 129 to 132 inclusive (IPv4 destination 224.0.1.129 to 224.0.1.132).
- R3: On a match, `domain` equals the byte at offset 33 minus 129: 0 for the default domain, and 1, 2 or 3 for alternate domains 1 to 3.
- R4: The UDP destination port is the big-endian value {offset 36, offset 37}. Port 319 gives `is_event`, port 320 gives `is_general`, and any other value gives no match. The source port bytes (offsets 34 and 35) have no effect.
- R5: On a match whose control byte at offset 74 is 0 to 4, `msg_type` equals that byte (0 Sync, 1 Delay_req, 2 Follow_up, 3 Delay_resp, 4 Management).
- R6: On a match whose control byte is greater than 4, `type_unknown` is 1 and `msg_type` is 0.
- R7: A frame that ends before offset 74 has been received (fewer than 75 bytes) never matches.
- R8: `gp_event` is 1 exactly when the reported verdict is a match.
- R9: `res_valid` is high for exactly the one cycle after the frame-end byte is accepted. When the verdict is no match, `is_event`, `is_general`, `msg_type`, `type_unknown`, `domain` and `gp_event` are all 0.
- R10: The offset count stops at 75. Any number of bytes past offset 74 leaves the verdict unchanged.
- R11: `s_ready` is always 1. Cycles with `s_valid` low change nothing, whatever `s_data`, `s_sof` and `s_eof` carry.
- R12: A synchronous active-high `rst` clears `res_valid` and all result flags, and restarts the offset count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Byte present on `s_data` |
| s_ready | output | 1 | Always high; the block never stalls |
| s_data | input | 8 | Frame byte |
| s_sof | input | 1 | Byte is offset 0 of a frame |
| s_eof | input | 1 | Byte is the last of a frame |
| res_valid | output | 1 | One-cycle pulse: verdict fields are valid |
| ptp_match | output | 1 | Frame is a recognised PTP message |
| is_event | output | 1 | Destination port 319 |
| is_general | output | 1 | Destination port 320 |
| msg_type | output | 3 | Message type code (0 to 4) |
| type_unknown | output | 1 | Matching frame with control byte above 4 |
| domain | output | 2 | Domain code from the last address octet |
| gp_event | output | 1 | General-purpose event bit for the filer |

## Verification
The bench aims at the edges of the length window, with frames of 74 and 75 bytes. A design that checks the control byte one offset off would accept the short frame or reject the longer one. It also sends frames of 200 bytes, where a counter that wraps instead of saturating would reopen the field windows and overwrite the verdict. The last address octet is driven to 128 and 133, and the port to 318 and 321, which catches range and equality compares that are off by one. Frames are restarted by a mid-frame start marker and by a mid-frame reset, and idle cycles carry junk markers, so a block that leaks state across frames or acts on unqualified markers reports a wrong verdict or a stray result pulse.

// File: rtl/ptp_cls_pkg.sv
package ptp_cls_pkg;

  // number of multicast groups recognised; the domain code is 2 bits wide
  localparam int unsigned GROUP_CNT = 4;

  typedef enum logic [2:0] {
    MT_SYNC     = 3'd0,
    MT_DLY_REQ  = 3'd1,
    MT_FOLLOW   = 3'd2,
    MT_DLY_RESP = 3'd3,
    MT_MGMT     = 3'd4
  } msg_code_e;

  typedef struct packed {
    logic       hit;
    logic       evt;
    logic       gen;
    logic       unk;
    logic [2:0] mtype;
    logic [1:0] dom;
  } verdict_t;

endpackage

// File: rtl/ptp_offset_ctr.sv
module ptp_offset_ctr #(
  parameter int unsigned OFF_W = 7,
  parameter int unsigned SAT   = 75
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             sof,
  input  logic             eof,
  output logic [OFF_W-1:0] off_now
);
  localparam logic [OFF_W-1:0] SAT_V = OFF_W'(SAT);

  logic [OFF_W-1:0] cnt_q;

  // a start marker forces offset 0; otherwise the running count applies
  assign off_now = sof ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (acc) begin
      if (eof)                 cnt_q <= '0;
      else if (off_now >= SAT_V) cnt_q <= SAT_V;
      else                     cnt_q <= off_now + 1'b1;
    end
  end

  // R10: the count never runs past its saturation point
  a_r10_ctr_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= SAT_V);

  // R1: after a frame-end byte the next byte starts at offset 0
  a_r1_restart_after_eof: assert property (@(posedge clk) disable iff (rst)
    (acc && eof) |=> (cnt_q == '0));

endmodule

// File: rtl/ptp_field_match.sv
module ptp_field_match
  import ptp_cls_pkg::*;
#(
  parameter int unsigned OFF_W        = 7,
  parameter int unsigned IP_OFF       = 30,
  parameter int unsigned DPORT_OFF    = 36,
  parameter int unsigned CTRL_OFF     = 74,
  parameter logic [31:0] GROUP_BASE   = 32'hE000_0181,
  parameter logic [15:0] EVENT_PORT   = 16'd319,
  parameter logic [15:0] GENERAL_PORT = 16'd320
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic [OFF_W-1:0] off,
  input  logic [7:0]       data,
  output verdict_t         vd_nx
);
  localparam logic [7:0] LO_OCT = GROUP_BASE[7:0];

  logic       ip_ok_q, evt_q, gen_q, seen_q;
  logic [1:0] dom_q;
  logic [7:0] phi_q, ctrl_q;

  logic       ip_ok_b, evt_b, gen_b, seen_b;
  logic [1:0] dom_b;
  logic [7:0] phi_b, ctrl_b;

  logic       ip_ok_n, evt_n, gen_n, seen_n;
  logic [1:0] dom_n;
  logic [7:0] phi_n, ctrl_n;
  logic [15:0] port_w;
  logic        fresh, last_pos, last_ok;

  // fixed leading octets of the multicast address, one compare per byte
  logic [2:0] fix_pos, fix_ok;
  for (genvar g = 0; g < 3; g++) begin : g_ip_fixed
    assign fix_pos[g] = (off == OFF_W'(IP_OFF + g));
    assign fix_ok[g]  = (data == GROUP_BASE[31-8*g -: 8]);
  end

  assign fresh    = (off == '0);
  assign last_pos = (off == OFF_W'(IP_OFF + 3));
  assign last_ok  = (data >= LO_OCT) &&
                    ({1'b0, data} < ({1'b0, LO_OCT} + 9'(GROUP_CNT)));
  assign port_w   = {phi_b, data};

  always_comb begin
    // offset 0 begins a new frame: start from clean per-frame state
    ip_ok_b = fresh ? 1'b1 : ip_ok_q;
    evt_b   = fresh ? 1'b0 : evt_q;
    gen_b   = fresh ? 1'b0 : gen_q;
    seen_b  = fresh ? 1'b0 : seen_q;
    dom_b   = fresh ? 2'd0 : dom_q;
    phi_b   = fresh ? 8'd0 : phi_q;
    ctrl_b  = fresh ? 8'd0 : ctrl_q;

    ip_ok_n = ip_ok_b & ~|(fix_pos & ~fix_ok) & ~(last_pos & ~last_ok);
    dom_n   = last_pos ? 2'(data - LO_OCT) : dom_b;

    phi_n   = (off == OFF_W'(DPORT_OFF)) ? data : phi_b;
    evt_n   = evt_b;
    gen_n   = gen_b;
    if (off == OFF_W'(DPORT_OFF + 1)) begin
      evt_n = (port_w == EVENT_PORT);
      gen_n = (port_w == GENERAL_PORT);
    end

    ctrl_n  = ctrl_b;
    seen_n  = seen_b;
    if (off == OFF_W'(CTRL_OFF)) begin
      ctrl_n = data;
      seen_n = 1'b1;
    end
  end

  // verdict as it would stand if the frame ended with the current byte
  always_comb begin
    vd_nx.hit   = ip_ok_n & (evt_n | gen_n) & seen_n;
    vd_nx.evt   = vd_nx.hit & evt_n;
    vd_nx.gen   = vd_nx.hit & gen_n;
    vd_nx.unk   = vd_nx.hit & (ctrl_n > 8'(MT_MGMT));
    vd_nx.mtype = (vd_nx.hit && !vd_nx.unk) ? ctrl_n[2:0] : 3'd0;
    vd_nx.dom   = vd_nx.hit ? dom_n : 2'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ip_ok_q <= 1'b0;
      evt_q   <= 1'b0;
      gen_q   <= 1'b0;
      seen_q  <= 1'b0;
      dom_q   <= 2'd0;
      phi_q   <= 8'd0;
      ctrl_q  <= 8'd0;
    end else if (acc) begin
      ip_ok_q <= ip_ok_n;
      evt_q   <= evt_n;
      gen_q   <= gen_n;
      seen_q  <= seen_n;
      dom_q   <= dom_n;
      phi_q   <= phi_n;
      ctrl_q  <= ctrl_n;
    end
  end

  // R4: one port value cannot be both the event and the general port
  a_r4_port_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(evt_q && gen_q));

  // R7: the control byte is never marked seen on the first byte of a frame
  a_r7_seen_needs_length: assert property (@(posedge clk) disable iff (rst)
    (acc && fresh) |=> !seen_q);

endmodule

// File: rtl/ptp_result_reg.sv
module ptp_result_reg
  import ptp_cls_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     acc,
  input  logic     eof,
  input  verdict_t vd_nx,
  output logic     res_valid,
  output verdict_t vd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      vd_q      <= '0;
    end else begin
      res_valid <= acc & eof;
      if (acc && eof) vd_q <= vd_nx;
    end
  end

  // R9: between pulses the reported verdict does not move
  a_r9_hold_between: assert property (@(posedge clk) disable iff (rst)
    !(acc && eof) |=> $stable(vd_q));

endmodule

// File: rtl/ptp_frame_classifier.sv
module ptp_frame_classifier
  import ptp_cls_pkg::*;
#(
  parameter int unsigned IP_OFF       = 30,
  parameter int unsigned DPORT_OFF    = 36,
  parameter int unsigned CTRL_OFF     = 74,
  parameter logic [31:0] GROUP_BASE   = 32'hE000_0181,
  parameter logic [15:0] EVENT_PORT   = 16'd319,
  parameter logic [15:0] GENERAL_PORT = 16'd320
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       s_sof,
  input  logic       s_eof,
  output logic       res_valid,
  output logic       ptp_match,
  output logic       is_event,
  output logic       is_general,
  output logic [2:0] msg_type,
  output logic       type_unknown,
  output logic [1:0] domain,
  output logic       gp_event
);
  localparam int unsigned SAT   = CTRL_OFF + 1;
  localparam int unsigned OFF_W = $clog2(SAT + 1);

  logic             acc;
  logic [OFF_W-1:0] off_now;
  verdict_t         vd_nx, vd_q;

  assign s_ready = 1'b1;
  assign acc     = s_valid & s_ready;

  ptp_offset_ctr #(.OFF_W(OFF_W), .SAT(SAT)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .acc     (acc),
    .sof     (s_sof),
    .eof     (s_eof),
    .off_now (off_now)
  );

  ptp_field_match #(
    .OFF_W        (OFF_W),
    .IP_OFF       (IP_OFF),
    .DPORT_OFF    (DPORT_OFF),
    .CTRL_OFF     (CTRL_OFF),
    .GROUP_BASE   (GROUP_BASE),
    .EVENT_PORT   (EVENT_PORT),
    .GENERAL_PORT (GENERAL_PORT)
  ) u_match (
    .clk   (clk),
    .rst   (rst),
    .acc   (acc),
    .off   (off_now),
    .data  (s_data),
    .vd_nx (vd_nx)
  );

  ptp_result_reg u_res (
    .clk       (clk),
    .rst       (rst),
    .acc       (acc),
    .eof       (s_eof),
    .vd_nx     (vd_nx),
    .res_valid (res_valid),
    .vd_q      (vd_q)
  );

  assign ptp_match    = vd_q.hit;
  assign is_event     = vd_q.evt;
  assign is_general   = vd_q.gen;
  assign type_unknown = vd_q.unk;
  assign msg_type     = vd_q.mtype;
  assign domain       = vd_q.dom;
  assign gp_event     = vd_q.hit;

  // R9: a pulse follows every accepted frame-end byte and nothing else
  a_r9_pulse_after_eof: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_eof) |=> res_valid);
  a_r9_no_stray_pulse: assert property (@(posedge clk) disable iff (rst)
    !(s_valid && s_eof) |=> !res_valid);

  // R4: a match is exactly one of event or general
  a_r4_kind_onehot: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ((is_event ^ is_general) == ptp_match));

  // R6: unknown type only on a match, and it carries no type code
  a_r6_unknown_shape: assert property (@(posedge clk) disable iff (rst)
    type_unknown |-> (ptp_match && msg_type == 3'd0));

  // R9: a non-matching verdict carries all-zero fields
  a_r9_nomatch_zero: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !ptp_match) |->
      (domain == 2'd0 && msg_type == 3'd0 && !type_unknown && !gp_event));

  // R8: the filer event bit follows the match
  a_r8_gp_event: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (gp_event == ptp_match));

  // R11: the block never stalls
  a_r11_always_ready: assert property (@(posedge clk) disable iff (rst)
    s_ready);

  // R12: no pulse on the cycle leaving reset
  a_r12_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !res_valid);

endmodule

// File: tb/ptp_frame_classifier_tb.sv
module ptp_frame_classifier_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       s_valid, s_sof, s_eof;
  logic [7:0] s_data;
  logic       s_ready, res_valid, ptp_match, is_event, is_general;
  logic       type_unknown, gp_event;
  logic [2:0] msg_type;
  logic [1:0] domain;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ptp_frame_classifier u_dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof),
    .res_valid(res_valid), .ptp_match(ptp_match), .is_event(is_event),
    .is_general(is_general), .msg_type(msg_type),
    .type_unknown(type_unknown), .domain(domain), .gp_event(gp_event)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] q[$];
  logic       e_valid = 1'b0;
  logic       e_hit = 1'b0, e_evt = 1'b0, e_gen = 1'b0, e_unk = 1'b0;
  logic [2:0] e_mt = 3'd0;
  logic [1:0] e_dom = 2'd0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      q.delete();
      e_valid = 0; e_hit = 0; e_evt = 0; e_gen = 0; e_unk = 0; e_mt = 0; e_dom = 0;
    end else begin
      e_valid = 0;
      if (s_valid) begin
        if (s_sof) q.delete();
        q.push_back(s_data);
        if (s_eof) begin
          int port;
          e_valid = 1;
          e_hit = 0; e_evt = 0; e_gen = 0; e_unk = 0; e_mt = 0; e_dom = 0;
          if (q.size() >= 75 && q[30] == 8'd224 && q[31] == 8'd0 && q[32] == 8'd1 &&
              q[33] >= 8'd129 && q[33] <= 8'd132) begin
            port = {q[36], q[37]};
            if (port == 319 || port == 320) begin
              e_hit = 1;
              e_evt = (port == 319);
              e_gen = (port == 320);
              e_dom = 2'(q[33] - 8'd129);
              if (q[74] > 8'd4) e_unk = 1;
              else e_mt = q[74][2:0];
            end
          end
          q.delete();
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    check("R9 res_valid", {7'd0, res_valid}, {7'd0, e_valid});
    check("R11 s_ready", {7'd0, s_ready}, 8'd1);
    if (e_valid) begin
      check("R2 ptp_match", {7'd0, ptp_match}, {7'd0, e_hit});
      check("R4 is_event", {7'd0, is_event}, {7'd0, e_evt});
      check("R4 is_general", {7'd0, is_general}, {7'd0, e_gen});
      check("R5 msg_type", {5'd0, msg_type}, {5'd0, e_mt});
      check("R6 type_unknown", {7'd0, type_unknown}, {7'd0, e_unk});
      check("R3 domain", {6'd0, domain}, {6'd0, e_dom});
      check("R8 gp_event", {7'd0, gp_event}, {7'd0, e_hit});
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle_junk();
    s_valid = 0;
    s_data  = 8'($urandom);
    s_sof   = 1'($urandom);
    s_eof   = 1'($urandom);
    @(negedge clk);
  endtask

  task automatic send(input int len, input int oct0, input int oct3,
                      input int dport, input int ctrl, input bit gaps, input bit term);
    logic [7:0] f[$];
    for (int i = 0; i < len; i++) f.push_back(8'($urandom));
    if (len > 30) f[30] = 8'(oct0);
    if (len > 31) f[31] = 8'd0;
    if (len > 32) f[32] = 8'd1;
    if (len > 33) f[33] = 8'(oct3);
    if (len > 36) f[36] = 8'(dport >> 8);
    if (len > 37) f[37] = 8'(dport);
    if (len > 74) f[74] = 8'(ctrl);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 3 == 0)) idle_junk();
      s_valid = 1;
      s_data  = f[i];
      s_sof   = (i == 0);
      s_eof   = term && (i == len - 1);
      @(negedge clk);
    end
    s_valid = 0; s_sof = 0; s_eof = 0;
  endtask

  initial begin
    rst = 1; s_valid = 0; s_sof = 0; s_eof = 0; s_data = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 res_valid after reset", {7'd0, res_valid}, 8'd0);
    check("R12 ptp_match after reset", {7'd0, ptp_match}, 8'd0);
    check("R12 domain after reset", {6'd0, domain}, 8'd0);
    rst = 0;
    @(negedge clk);

    // R3: every domain, event port
    for (int d = 0; d < 4; d++) begin
      send(90, 224, 129 + d, 319, d, 0, 1);
      check("R3 directed domain", {6'd0, domain}, 8'(d));
      idle_junk();
    end
    // R2: address outside the group range
    send(90, 224, 128, 319, 0, 1, 1);
    check("R2 octet 128 rejected", {7'd0, ptp_match}, 8'd0);
    send(90, 224, 133, 320, 0, 1, 1);
    check("R2 octet 133 rejected", {7'd0, ptp_match}, 8'd0);
    send(90, 225, 129, 319, 0, 0, 1);
    // R4: ports
    send(80, 224, 130, 320, 2, 1, 1);
    check("R4 general port", {7'd0, is_general}, 8'd1);
    send(80, 224, 130, 318, 2, 0, 1);
    send(80, 224, 130, 321, 2, 0, 1);
    send(80, 224, 130, 319 + 256, 2, 0, 1);
    // R5 / R6: every control code and beyond
    for (int c = 0; c < 8; c++) send(76, 224, 131, 319 + (c % 2), c, 1, 1);
    send(76, 224, 131, 320, 255, 0, 1);
    check("R6 control 0xFF unknown", {7'd0, type_unknown}, 8'd1);
    // R7: length window
    send(74, 224, 129, 319, 0, 0, 1);
    check("R7 74-byte frame", {7'd0, ptp_match}, 8'd0);
    send(75, 224, 129, 319, 1, 0, 1);
    check("R7 75-byte frame", {7'd0, ptp_match}, 8'd1);
    send(40, 224, 129, 319, 0, 1, 1);
    send(1, 224, 129, 319, 0, 0, 1);
    send(1, 224, 129, 319, 0, 0, 1);
    // R10: long frames
    send(200, 224, 132, 320, 4, 1, 1);
    check("R10 long frame match", {7'd0, ptp_match}, 8'd1);
    check("R10 long frame type", {5'd0, msg_type}, 8'd4);
    // R1: start marker mid-frame restarts
    send(50, 224, 129, 319, 0, 0, 0);
    send(80, 224, 130, 319, 3, 0, 1);
    check("R1 restart by sof", {6'd0, domain}, 8'd1);
    // R1: frame without start marker after an end byte is offset 0
    send(80, 224, 131, 319, 1, 0, 1);
    s_valid = 1; s_sof = 0; s_data = 8'h00; s_eof = 0;
    for (int i = 0; i < 79; i++) begin
      s_data = (i == 30) ? 8'd224 : (i == 32) ? 8'd1 : (i == 33) ? 8'd132 :
               (i == 36) ? 8'd1 : (i == 37) ? 8'd63 : 8'd0;
      @(negedge clk);
    end
    s_data = 8'd7; s_eof = 1;
    @(negedge clk);
    s_valid = 0; s_eof = 0;
    check("R1 no-sof frame domain", {6'd0, domain}, 8'd3);
    // R12: reset in the middle of a frame
    send(60, 224, 129, 319, 0, 0, 0);
    rst = 1;
    @(negedge clk);
    check("R12 mid-frame reset clears", {7'd0, ptp_match}, 8'd0);
    rst = 0;
    send(80, 224, 129, 320, 2, 1, 1);
    // R11: long idle stretch with junk markers, then a random-body mix
    repeat (20) idle_junk();
    check("R11 idle junk no pulse", {7'd0, res_valid}, 8'd0);
    for (int k = 0; k < 300; k++)
      send(60 + int'($urandom % 40), 224, 127 + int'($urandom % 8),
           318 + int'($urandom % 4), int'($urandom % 7), 1, 1);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule